// File: doc/BRIEF.md
# Dual Prescaled Counter Timer Unit

This block holds two down-counters, channel 0 and channel 1. Each one is stepped through its own prescaler. A byte-wide register port sets each channel's reload value and prescaler setting. A shared mode register loads and enables the channels, picks the behaviour of an external timer input pin, and picks which channel drives a toggle output. Channel 0 always counts a clock derived from the system clock. That clock is one pulse every eight system clocks. Channel 1 counts either the same derived clock or the external pin. When it uses the pin, the pin acts in one of four ways: as a clock, as a gate, as a one-shot trigger, or as a retrigger.

When a channel reaches the end of its count, it raises a one-cycle interrupt request pulse. In continuous mode the channel then reloads and runs on. In single-pass mode it stops and its enable bit in the mode register drops. The toggle output is forced high when its selected channel is loaded, and it flips each time that channel reaches the end of its count. Reading a counter address returns the live count.

Each channel is run by a small state machine with four states. CH_OFF means the channel is disabled and does not count. CH_WAIT means it is enabled and is waiting for a trigger edge. CH_RUN means it is counting. CH_HOLD means it is suspended because the gate is low. The transitions are:
- CH_OFF moves to CH_WAIT, CH_RUN or CH_HOLD once enabled, depending on the input mode and the gate level.
- CH_WAIT moves to CH_RUN on a trigger edge, which reloads the count.
- CH_RUN moves to CH_HOLD when the gate goes low, and to CH_OFF at a single-pass end of count.
- CH_HOLD moves back to CH_RUN when the gate goes high.
- From any state, clearing the enable bit returns the channel to CH_OFF.

Top module: `dual_cnt_timer`

## Requirements
- R1: After reset both counts read 0, the mode register reads 0x00, the toggle output is high and both interrupt outputs are low.
- R2: The register addresses are 0 (channel 0 reload on write, live count on read), 1 (channel 0 prescaler), 2 (channel 1 reload on write, live count on read), 3 (channel 1 prescaler) and 4 (mode). The prescaler registers read back exactly as written. Mode bits 0 (load channel 0) and 2 (load channel 1) read back as 0. A load copies the reload value into the count, so the count reads back as the reload value.
- R3: A prescaler register holds its divide value P in bits 7:2, where 0 means 64. A reload value N of 0 means 256. Each count step is one derived-clock pulse, and the derived clock pulses once every 8 system clocks. In continuous mode (prescaler bit 0 = 1), end-of-count pulses therefore come exactly N×P×8 clocks apart.
- R4: In single-pass mode (prescaler bit 0 = 0), the channel gives one end-of-count pulse. It then stops with its count at 0, and its enable bit (mode bit 1 for channel 0, mode bit 3 for channel 1) is cleared.
- R5: Channel 0 end of count drives irq_t0 and channel 1 end of count drives irq_t1. Each is a pulse exactly one cycle long.
- R6: Mode bits 7:6 select the toggle source: 00 off, 01 channel 0, 10 channel 1. Loading the selected channel drives the toggle output high. Each end of count of the selected channel inverts it. When the field is 00, the toggle output holds its value.
- R7: Channel 1 prescaler bit 1 = 1 selects the derived clock. When it is 0, the pin is used in the mode set by mode bits 5:4. With bits 5:4 = 00, each falling edge of the synchronized pin is one count step, and the count holds while no edge arrives.
- R8: With bits 5:4 = 01 (gate), channel 1 counts derived-clock pulses only while the pin is high, and its count holds while the pin is low.
- R9: With bits 5:4 = 10 (trigger), an enabled channel 1 does not count until a falling edge of the pin. The edge starts it from its reload value. Further edges while it is running are ignored.
- R10: With bits 5:4 = 11 (retrigger), every falling edge of the pin while channel 1 is enabled restarts it from its reload value.
- R11: When both channels reach the end of count in the same cycle, both interrupt pulses appear in the same cycle. The toggle output flips once, for its selected channel only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| tin | input | 1 | External timer input pin (asynchronous) |
| tout | output | 1 | Toggle output |
| irq_t0 | output | 1 | Channel 0 end-of-count pulse |
| irq_t1 | output | 1 | Channel 1 end-of-count pulse |

## Verification
The two channels can reach the end of count in the same cycle. When that happens the two interrupt paths and the single toggle path must all act independently. The bench provokes this by giving both channels the same reload and prescale values and loading and enabling them with one mode write, so that both count from the same derived-clock phase. It then requires both interrupt pulses on the same sampled cycle, and a toggle output that has flipped exactly once, as set by the channel chosen in the toggle field.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_RUN  = 2'd2,
        CH_HOLD = 2'd3
    } ch_state_t;

    localparam logic [2:0] A_T0   = 3'd0;
    localparam logic [2:0] A_P0   = 3'd1;
    localparam logic [2:0] A_T1   = 3'd2;
    localparam logic [2:0] A_P1   = 3'd3;
    localparam logic [2:0] A_MODE = 3'd4;

    localparam logic [1:0] IN_CLK  = 2'b00;
    localparam logic [1:0] IN_GATE = 2'b01;
    localparam logic [1:0] IN_RTRG = 2'b11;

    localparam logic [1:0] TO_CH0 = 2'b01;
    localparam logic [1:0] TO_CH1 = 2'b10;

endpackage

// File: rtl/tin_sync.sv
module tin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign lvl  = sh_q[STAGES-1];
    assign fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import dct_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cont,
    input  logic             need_trig,
    input  logic             retrig,
    input  logic             trig,
    input  logic             gate_ok,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] rld,
    input  logic [PRE_W-1:0] pre,
    output logic [CNT_W-1:0] cnt,
    output logic             eoc
);
    ch_state_t        st_q, st_nx;
    logic [PRE_W-1:0] pcnt_q;
    logic             restart, adv, last;

    always_comb begin
        restart = trig & ((st_q == CH_WAIT) | ((st_q == CH_RUN) & retrig));
        adv     = (st_q == CH_RUN) & gate_ok & step & ~load & ~restart;
        last    = (pcnt_q == PRE_W'(1)) & (cnt == CNT_W'(1));
        eoc     = adv & last;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CH_OFF: begin
                if (en) st_nx = need_trig ? CH_WAIT : (gate_ok ? CH_RUN : CH_HOLD);
            end
            CH_WAIT: begin
                if (!en)       st_nx = CH_OFF;
                else if (trig) st_nx = CH_RUN;
            end
            CH_RUN: begin
                if (!en)               st_nx = CH_OFF;
                else if (eoc && !cont) st_nx = CH_OFF;
                else if (!gate_ok)     st_nx = CH_HOLD;
            end
            CH_HOLD: begin
                if (!en)          st_nx = CH_OFF;
                else if (gate_ok) st_nx = CH_RUN;
            end
            default: st_nx = CH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            pcnt_q <= '0;
        end else if (load || restart) begin
            cnt    <= rld;
            pcnt_q <= pre;
        end else if (adv) begin
            if (pcnt_q == PRE_W'(1)) begin
                pcnt_q <= pre;
                if (cnt == CNT_W'(1)) cnt <= cont ? rld : '0;
                else                  cnt <= cnt - CNT_W'(1);
            end else begin
                pcnt_q <= pcnt_q - PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/dual_cnt_timer.sv
module dual_cnt_timer
    import dct_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             tin,
    output logic             tout,
    output logic             irq_t0,
    output logic             irq_t1
);
    localparam int PRE_W = CNT_W - 2;
    localparam int NCH   = 2;

    logic [NCH-1:0][CNT_W-1:0] rld_q, pre_q, cnt_v;
    logic [7:0]                mode_q;
    logic [DIV_W-1:0]          div_q;
    logic                      tick, tin_lvl, tin_fall, t1_ext, we_mode;
    logic [NCH-1:0]            en_v, cont_v, ntrig_v, retrig_v, trig_v;
    logic [NCH-1:0]            gate_v, step_v, load_v, eoc_v;
    logic [CNT_W-1:0]          cnt1_w;
    logic                      tout_set, tout_tog;

    tin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(tin), .lvl(tin_lvl), .fall(tin_fall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + DIV_W'(1);
    end
    assign tick    = &div_q;
    assign t1_ext  = ~pre_q[1][1];
    assign we_mode = wr_en && (wr_addr == A_MODE);
    assign cnt1_w  = cnt_v[1];

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        if (gi == 0) begin : g_plain
            assign ntrig_v[gi]  = 1'b0;
            assign retrig_v[gi] = 1'b0;
            assign trig_v[gi]   = 1'b0;
            assign gate_v[gi]   = 1'b1;
            assign step_v[gi]   = tick;
        end else begin : g_pin
            assign ntrig_v[gi]  = t1_ext & mode_q[5];
            assign retrig_v[gi] = t1_ext & (mode_q[5:4] == IN_RTRG);
            assign trig_v[gi]   = tin_fall & ntrig_v[gi];
            assign gate_v[gi]   = ~(t1_ext & (mode_q[5:4] == IN_GATE)) | tin_lvl;
            assign step_v[gi]   = (t1_ext && mode_q[5:4] == IN_CLK) ? tin_fall : tick;
        end
        assign en_v[gi]   = mode_q[1 + 2*gi];
        assign cont_v[gi] = pre_q[gi][0];
        assign load_v[gi] = we_mode & wr_data[2*gi];

        tmr_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .en(en_v[gi]), .cont(cont_v[gi]),
            .need_trig(ntrig_v[gi]), .retrig(retrig_v[gi]), .trig(trig_v[gi]),
            .gate_ok(gate_v[gi]), .step(step_v[gi]), .load(load_v[gi]),
            .rld(rld_q[gi]), .pre(pre_q[gi][CNT_W-1:2]),
            .cnt(cnt_v[gi]), .eoc(eoc_v[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
            pre_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_T0: rld_q[0] <= wr_data;
                A_P0: pre_q[0] <= wr_data;
                A_T1: rld_q[1] <= wr_data;
                A_P1: pre_q[1] <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (we_mode) begin
            mode_q <= wr_data[7:0] & 8'hFA;
        end else begin
            if (eoc_v[0] && !cont_v[0]) mode_q[1] <= 1'b0;
            if (eoc_v[1] && !cont_v[1]) mode_q[3] <= 1'b0;
        end
    end

    assign tout_set = (load_v[0] && wr_data[7:6] == TO_CH0) ||
                      (load_v[1] && wr_data[7:6] == TO_CH1);
    assign tout_tog = (mode_q[7:6] == TO_CH0 && eoc_v[0]) ||
                      (mode_q[7:6] == TO_CH1 && eoc_v[1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tout   <= 1'b1;
            irq_t0 <= 1'b0;
            irq_t1 <= 1'b0;
        end else begin
            irq_t0 <= eoc_v[0];
            irq_t1 <= eoc_v[1];
            if (tout_set)      tout <= 1'b1;
            else if (tout_tog) tout <= ~tout;
        end
    end

    always_comb begin
        case (rd_addr)
            A_T0:    rd_data = cnt_v[0];
            A_P0:    rd_data = pre_q[0];
            A_T1:    rd_data = cnt_v[1];
            A_P1:    rd_data = pre_q[1];
            A_MODE:  rd_data = CNT_W'(mode_q);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dct_chk.sv
module dct_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             irq_t0,
    input logic             irq_t1,
    input logic             tout,
    input logic             t1_ext,
    input logic             tin_lvl,
    input logic [1:0]       cont_v,
    input logic [7:0]       mode_q,
    input logic [CNT_W-1:0] cnt1
);
    // R5
    irq0_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_t0 |=> !irq_t0);

    // R5
    irq1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_t1 |=> !irq_t1);

    // R6
    tout_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tout) |-> (irq_t0 || irq_t1));

    // R4
    single0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_t0 && !$past(wr_en) && !$past(cont_v[0])) |-> !mode_q[1]);

    // R4
    single1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_t1 && !$past(wr_en) && !$past(cont_v[1])) |-> !mode_q[3]);

    // R8
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $past(mode_q[5:4]) == 2'b01 && $past(t1_ext) && !$past(tin_lvl))
        |-> cnt1 == $past(cnt1));
endmodule

bind dual_cnt_timer dct_chk #(.CNT_W(CNT_W)) u_dct_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq_t0(irq_t0), .irq_t1(irq_t1),
    .tout(tout), .t1_ext(t1_ext), .tin_lvl(tin_lvl), .cont_v(cont_v),
    .mode_q(mode_q), .cnt1(cnt1_w)
);

// File: tb/test_dual_cnt_timer.sv
module test_dual_cnt_timer;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tin = 1'b1;
    logic       tout, irq_t0, irq_t1;

    int nchk = 0, nfail = 0;
    int irq0_n = 0, irq1_n = 0, dbl = 0;
    logic p0 = 1'b0, p1 = 1'b0;

    dual_cnt_timer i_dual_cnt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tin(tin), .tout(tout),
        .irq_t0(irq_t0), .irq_t1(irq_t1)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) begin
        if (irq_t0) irq0_n++;
        if (irq_t1) irq1_n++;
        if ((irq_t0 && p0) || (irq_t1 && p1)) dbl++;
        p0 = irq_t0;
        p1 = irq_t1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_irq(input int ch, input int lim, output int gap, output bit got);
        gap = 0; got = 1'b0;
        while (!got && gap < lim) begin
            @(negedge clk);
            gap++;
            if (ch == 1 ? irq_t1 : irq_t0) got = 1'b1;
        end
    endtask

    task automatic meas(input int ch, input int n, input int p);
        int ne, pe, gap;
        bit got;
        ne = (n == 0) ? 256 : n;
        pe = (p == 0) ? 64 : p;
        wr(ch == 1 ? 3'd2 : 3'd0, 8'(n));
        wr(ch == 1 ? 3'd3 : 3'd1, 8'((p << 2) | 1 | (ch == 1 ? 2 : 0)));
        wr(3'd4, ch == 1 ? 8'h0C : 8'h03);
        wait_irq(ch, ne*pe*16 + 64, gap, got);
        wait_irq(ch, ne*pe*8 + 64, gap, got);
        chk(got && gap == ne*pe*8, "R3 period", gap, ne*pe*8);
        wr(3'd4, 8'h00);
    endtask

    task automatic pulse();
        @(negedge clk); tin = 1'b0;
        repeat (3) @(negedge clk);
        tin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic trig_run(input logic [7:0] md, output int dt);
        int v, base;
        wr(3'd4, 8'h00);
        tin = 1'b1;
        idle(10);
        wr(3'd2, 8'd10);
        wr(3'd3, 8'h04);
        wr(3'd4, md);
        base = irq1_n;
        idle(60);
        rd(3'd2, v);
        chk(v == 10, "R9 count before edge", v, 10);
        chk(irq1_n == base, "R9 no start without edge", irq1_n - base, 0);
        @(negedge clk); tin = 1'b0; dt = 0;
        repeat (20) begin @(negedge clk); dt++; end
        tin = 1'b1;
        repeat (20) begin @(negedge clk); dt++; end
        tin = 1'b0;
        while (!irq_t1 && dt < 300) begin @(negedge clk); dt++; end
        tin = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int v, v2, dt, base, gap;
        bit got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(3'd0, v); chk(v == 0, "R1 count0", v, 0);
        rd(3'd2, v); chk(v == 0, "R1 count1", v, 0);
        rd(3'd4, v); chk(v == 0, "R1 mode", v, 0);
        chk(tout == 1'b1, "R1 tout", int'(tout), 1);
        chk(!irq_t0 && !irq_t1, "R1 irq", int'(irq_t0) + int'(irq_t1), 0);

        // R2 register map
        wr(3'd0, 8'h37); wr(3'd1, 8'h15); wr(3'd4, 8'h01);
        rd(3'd0, v); chk(v == 8'h37, "R2 load copies reload", v, 8'h37);
        rd(3'd1, v); chk(v == 8'h15, "R2 prescaler readback", v, 8'h15);
        rd(3'd4, v); chk(v == 0, "R2 load bit reads 0", v, 0);
        wr(3'd4, 8'h35);
        rd(3'd4, v); chk(v == 8'h30, "R2 mode load bits dropped", v, 8'h30);
        wr(3'd4, 8'h00);

        // R3 period sweep on both channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int n = 1; n <= 5; n += 2)
                for (int p = 1; p <= 3; p++) meas(ch, n, p);
            meas(ch, 2, 2);
            meas(ch, 0, 1);
            meas(ch, 1, 0);
            meas(ch, 0, 2);
        end

        // R4 single pass on channel 0
        wr(3'd0, 8'd2); wr(3'd1, 8'h04); wr(3'd4, 8'h03);
        wait_irq(0, 200, gap, got);
        chk(got, "R4 single-pass fires", int'(got), 1);
        rd(3'd4, v); chk((v & 2) == 0, "R4 enable cleared", v & 2, 0);
        rd(3'd0, v); chk(v == 0, "R4 count at 0", v, 0);
        base = irq0_n; idle(100);
        chk(irq0_n == base, "R4 no further pulse", irq0_n - base, 0);

        // R7 external clock on channel 1
        wr(3'd4, 8'h00);
        wr(3'd2, 8'd3); wr(3'd3, 8'h09); wr(3'd4, 8'h0C);
        base = irq1_n;
        repeat (5) pulse();
        idle(2);
        rd(3'd2, v); chk(v == 1, "R7 count after 5 edges", v, 1);
        chk(irq1_n == base, "R7 no pulse before 6 edges", irq1_n - base, 0);
        pulse(); idle(2);
        chk(irq1_n == base + 1, "R7 pulse on 6th edge", irq1_n - base, 1);
        rd(3'd2, v); chk(v == 3, "R7 continuous reload", v, 3);
        idle(50);
        rd(3'd2, v); chk(v == 3, "R7 holds without edges", v, 3);

        // R8 gate
        wr(3'd4, 8'h00);
        tin = 1'b0; idle(5);
        wr(3'd2, 8'd2); wr(3'd3, 8'h05); wr(3'd4, 8'h1C);
        base = irq1_n; idle(100);
        rd(3'd2, v); chk(v == 2, "R8 held while low", v, 2);
        chk(irq1_n == base, "R8 no pulse while low", irq1_n - base, 0);
        tin = 1'b1; idle(45);
        chk(irq1_n >= base + 1, "R8 counts while high", irq1_n - base, 1);
        tin = 1'b0; idle(5);
        base = irq1_n;
        rd(3'd2, v); idle(60); rd(3'd2, v2);
        chk(v == v2, "R8 suspended count", v2, v);
        chk(irq1_n == base, "R8 no pulse suspended", irq1_n - base, 0);
        tin = 1'b1;

        // R9 trigger: second edge ignored
        trig_run(8'h2C, dt);
        chk(dt >= 70 && dt <= 95, "R9 trigger timing", dt, 80);
        idle(2);
        rd(3'd4, v); chk((v & 8) == 0, "R9 single-pass stop", v & 8, 0);

        // R10 retrigger: second edge restarts
        trig_run(8'h3C, dt);
        chk(dt >= 105 && dt <= 135, "R10 retrigger timing", dt, 120);

        // R11 coincident end of count, toggle on channel 1
        wr(3'd4, 8'h00);
        wr(3'd0, 8'd2); wr(3'd1, 8'h05); wr(3'd2, 8'd2); wr(3'd3, 8'h07);
        wr(3'd4, 8'h8F);
        chk(tout == 1'b1, "R6 tout high after load", int'(tout), 1);
        got = 1'b0; gap = 0;
        while (!got && gap < 100) begin
            @(negedge clk); gap++;
            if (irq_t0 || irq_t1) got = 1'b1;
        end
        chk(irq_t0 && irq_t1, "R11 both pulses same cycle",
            int'(irq_t0) + int'(irq_t1), 2);
        chk(tout == 1'b0, "R11 single toggle", int'(tout), 0);
        wait_irq(1, 100, gap, got);
        chk(tout == 1'b1, "R6 second toggle", int'(tout), 1);
        wait_irq(1, 100, gap, got);
        chk(tout == 1'b0, "R6 third toggle", int'(tout), 0);

        // R6 toggle off holds, then reselect channel 0
        wr(3'd4, 8'h0A);
        base = irq0_n; idle(60);
        chk(irq0_n > base, "R6 channels still running", irq0_n - base, 1);
        chk(tout == 1'b0, "R6 off holds", int'(tout), 0);
        wr(3'd4, 8'h43);
        chk(tout == 1'b1, "R6 load of ch0 sets high", int'(tout), 1);
        wait_irq(0, 100, gap, got);
        chk(tout == 1'b0, "R6 ch0 toggles", int'(tout), 0);
        wr(3'd4, 8'h00);

        // R5 pulse width over the whole run
        chk(dbl == 0, "R5 one-cycle pulses", dbl, 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule